// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus side of a serial EEPROM. It follows the two-wire serial clock and data lines of an I2C bus, after re-timing them into a faster system clock domain. It tracks START and STOP framing and decodes the slave address byte. It answers the master with acknowledge bits and pulls SDA low, open-drain, to send read data. Each byte that the bus transfers to or from the array becomes one request on a valid/ready memory channel. A separate write sequencer tells the engine when an internal programming cycle is running.

A write transfer carries two word-address bytes and then any number of data bytes. Each data byte produces one write request at the current pointer, and the pointer then advances. A read transfer streams bytes from the pointer. The engine asks for the next byte each time the master acknowledges. The pointer survives a repeated START, so a master selects a random read address with a write header that has no data bytes.

Back-pressure rules on the request channel: `req_valid_o` rises with all request fields set, and the engine holds them unchanged until a cycle with `req_ready_i` high. The memory side must accept each request within one byte time on the bus. For every accepted read request it must return exactly one `rsp_valid_i` pulse, and that pulse must arrive before the SCL falling edge that ends the acknowledge bit.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, SDA is released (`sda_pull_o` = 0) and no request is pending (`req_valid_o` = 0).
- R2: An address byte after START is acknowledged only when bits 7:4 equal binary 1010 and bits 3:1 equal `strap_i`. Bit 0 set to 1 means read, 0 means write. The acknowledge is SDA held low during the ninth SCL high phase. Any other address byte gets no acknowledge.
- R3: While `busy_i` is high, a matching address byte is not acknowledged. SDA stays released for the rest of that transfer.
- R4: In a write, the two bytes after the address form the word pointer, high byte first. Bit 7 of the high byte is ignored. Each byte is acknowledged.
- R5: Each further write byte is acknowledged and issues one write request (`req_write_o` = 1) carrying the pointer and the byte. The pointer then increments.
- R6: In a read, the byte at the pointer is sent MSB first. The engine continues with the byte at the next address for as long as the master acknowledges. The pointer wraps from 0x7FFF to 0x0000.
- R7: After a master NACK, the engine releases SDA and issues no further read request.
- R8: A START in the middle of a byte aborts the transfer without a write request. The engine then takes the next byte as an address byte, and the pointer keeps its value.
- R9: SCL clocks with no preceding START get no acknowledge. A STOP returns the engine to idle with SDA released.
- R10: A request stays valid, with stable address, data and direction, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus (asynchronous) |
| sda_i | input | 1 | Serial data as seen on the bus (asynchronous) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Pin-strapped device select bits |
| busy_i | input | 1 | Internal programming cycle in progress |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory request accepted |
| req_write_o | output | 1 | 1 write, 0 read |
| req_addr_o | output | AW | Byte address of the request |
| req_wdata_o | output | 8 | Write data |
| rsp_valid_i | input | 1 | Read data valid pulse |
| rsp_data_i | input | 8 | Read data |

## Verification
The hardest state to reach from the ports is a START that arrives while a byte is only partly shifted in. A write header has just loaded the pointer at that point. The bench clocks four data bits, raises SDA during SCL low and then drops it while SCL is high. It checks that the next byte is taken as an address, that no write request was issued, and that a following read returns the byte at the pointer the header loaded. The pointer wrap is reached by loading 0x7FFE and acknowledging two reads in a row.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_TX_ACK
  } i2cs_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          inc,
  input  logic [7:0]    byte_i,
  output logic [AW-1:0] ptr_o
);
  localparam int HI_BITS = AW - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_o <= '0;
    else if (ld_hi) ptr_o[AW-1:8] <= byte_i[HI_BITS-1:0];
    else if (ld_lo) ptr_o[7:0] <= byte_i;
    else if (inc)   ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2cs_pkg::*;
#(
  parameter int AW     = 15,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  input  logic [2:0]    strap_i,
  input  logic          busy_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [7:0]    req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [7:0]    rsp_data_i
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic [1:0]  bus_s;
  logic        scl_s, sda_s;
  logic        scl_rise, scl_fall, start_det, stop_det;
  i2cs_state_e state, after_ack;
  logic [3:0]  bitcnt, txcnt;
  logic [7:0]  shreg, txbuf;
  logic [AW-1:0] ptr;
  logic        in_devaddr, byte_end, addr_hit;
  logic        ld_hi, ld_lo, wr_go, rd_go_dev, rd_go_ack, ptr_inc;

  i2cs_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .inc(ptr_inc), .byte_i(shreg), .ptr_o(ptr)
  );

  assign in_devaddr = (state == ST_DEVADDR);

  always_comb begin
    byte_end  = scl_fall && (bitcnt == BITS_PER_BYTE) && !start_det && !stop_det;
    addr_hit  = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !busy_i;
    ld_hi     = byte_end && (state == ST_ADDR_HI);
    ld_lo     = byte_end && (state == ST_ADDR_LO);
    wr_go     = byte_end && (state == ST_WDATA);
    rd_go_dev = byte_end && in_devaddr && addr_hit && shreg[0];
    rd_go_ack = scl_rise && (state == ST_TX_ACK) && !sda_s && !start_det && !stop_det;
    ptr_inc   = wr_go || rd_go_dev || rd_go_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      after_ack   <= ST_IDLE;
      bitcnt      <= '0;
      txcnt       <= '0;
      shreg       <= '0;
      txbuf       <= '0;
      sda_pull_o  <= 1'b0;
      req_valid_o <= 1'b0;
      req_write_o <= 1'b0;
      req_addr_o  <= '0;
      req_wdata_o <= '0;
    end else begin
      if (req_valid_o && req_ready_i) req_valid_o <= 1'b0;
      if (ptr_inc) begin
        req_valid_o <= 1'b1;
        req_write_o <= wr_go;
        req_addr_o  <= ptr;
        req_wdata_o <= shreg;
      end
      if (rsp_valid_i) txbuf <= rsp_data_i;

      if (start_det) begin
        state      <= ST_DEVADDR;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          ST_DEVADDR, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
            if (scl_rise && bitcnt < BITS_PER_BYTE) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_end) begin
              bitcnt <= '0;
              if (in_devaddr && !addr_hit) begin
                state <= ST_IDLE;
              end else begin
                sda_pull_o <= 1'b1;
                state      <= ST_ACK;
                case (state)
                  ST_DEVADDR: after_ack <= shreg[0] ? ST_TX : ST_ADDR_HI;
                  ST_ADDR_HI: after_ack <= ST_ADDR_LO;
                  default:    after_ack <= ST_WDATA;
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state  <= after_ack;
              bitcnt <= '0;
              if (after_ack == ST_TX) begin
                sda_pull_o <= ~txbuf[7];
                txcnt      <= 4'd1;
              end else begin
                sda_pull_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (txcnt == BITS_PER_BYTE) begin
                sda_pull_o <= 1'b0;
                state      <= ST_TX_ACK;
              end else begin
                sda_pull_o <= ~txbuf[3'd7 - txcnt[2:0]];
                txcnt      <= txcnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                state     <= ST_ACK;
                after_ack <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_pull,
  input logic          busy_i,
  input logic          in_devaddr,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [7:0]    req_wdata
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)); // R10

  AST_PULL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl); // R2

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_devaddr && busy_i |=> !sda_pull); // R3

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull); // R9
endmodule

bind i2c_eeprom_slave i2cs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(sda_pull_o), .busy_i(busy_i),
  .in_devaddr(in_devaddr), .req_valid(req_valid_o), .req_ready(req_ready_i),
  .req_write(req_write_o), .req_addr(req_addr_o), .req_wdata(req_wdata_o)
);

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int AW = 15;
  localparam int Q  = 10;
  localparam logic [2:0] STRAP = 3'b101;
  // {address byte, busy, expected ack}
  localparam logic [9:0] VECS [8] = '{
    {8'hAA, 1'b0, 1'b1}, {8'hA8, 1'b0, 1'b0}, {8'hAE, 1'b0, 1'b0},
    {8'h2A, 1'b0, 1'b0}, {8'hBA, 1'b0, 1'b0}, {8'hEA, 1'b0, 1'b0},
    {8'hA2, 1'b0, 1'b0}, {8'hAA, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_pull, req_valid, req_ready = 1'b0, req_write;
  logic [AW-1:0] req_addr;
  logic [7:0] req_wdata, rsp_data = '0;
  logic rsp_valid = 1'b0;
  wire  sda_line = m_sda & ~sda_pull;

  int total = 0, fails = 0, cyc = 0;
  int wr_n = 0, rd_n = 0, rd_served = 0;
  logic [AW-1:0] wr_addr [8];
  logic [7:0]    wr_data [8];
  logic [AW-1:0] rd_addr_q = '0;
  logic [1:0]    rdy_cnt = '0;

  always #4 clk = ~clk;

  i2c_eeprom_slave #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(STRAP), .busy_i(busy),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data)
  );

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  // memory model: capture handshakes, drive ready and responses away from the edge
  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      if (req_write) begin
        if (wr_n < 8) begin
          wr_addr[wr_n] <= req_addr;
          wr_data[wr_n] <= req_wdata;
        end
        wr_n <= wr_n + 1;
      end else begin
        rd_addr_q <= req_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    rdy_cnt   = rdy_cnt + 1'b1;
    req_ready = (rdy_cnt == 2'd3);
    if (rd_served != rd_n) begin
      rsp_valid = 1'b1;
      rsp_data  = mem_f(rd_addr_q);
      rd_served = rd_served + 1;
    end else begin
      rsp_valid = 1'b0;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(Q); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wq(Q); m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0;
    end
  endtask

  task automatic byte_out(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    wq(Q); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); ack = ~sda_line; wq(Q); m_scl = 1'b0;
  endtask

  task automatic byte_in(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); m_scl = 1'b0;
    end
    wq(Q); m_sda = ~give_ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0;
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    int wr0, rd0;
    wq(5);
    rst_n = 1'b1;
    wq(2);
    chk("R1 sda released after reset", sda_pull, 0);
    chk("R1 no request after reset", req_valid, 0);

    // R9: clocks without START get no acknowledge
    m_scl = 1'b0;
    byte_out(8'hAA, a);
    chk("R9 no ack without START", a, 0);
    bus_stop();

    // address decode table (R2, R3)
    foreach (VECS[k]) begin
      busy = VECS[k][1];
      bus_start();
      byte_out(VECS[k][9:2], a);
      chk("R2 R3 address byte ack", a, VECS[k][0]);
      if (VECS[k][1]) begin
        byte_out(8'h00, a);
        chk("R3 silent for rest of transfer", a, 0);
        chk("R3 sda released", sda_pull, 0);
      end
      bus_stop();
      busy = 1'b0;
    end

    // write: bit 15 ignored, two data bytes under back-pressure
    wr0 = wr_n;
    bus_start();
    byte_out(8'hAA, a);
    byte_out(8'h81, a); chk("R4 high address byte ack", a, 1);
    byte_out(8'h23, a); chk("R4 low address byte ack", a, 1);
    byte_out(8'h5E, a); chk("R5 data byte ack", a, 1);
    byte_out(8'h77, a); chk("R5 second data byte ack", a, 1);
    bus_stop();
    wq(20);
    chk("R10 write requests accepted", wr_n - wr0, 2);
    chk("R4 first write address", wr_addr[wr0], 15'h0123);
    chk("R5 first write data", wr_data[wr0], 8'h5E);
    chk("R5 pointer increments", wr_addr[wr0+1], 15'h0124);
    chk("R10 second write data", wr_data[wr0+1], 8'h77);
    chk("R9 idle after stop", sda_pull, 0);

    // random read across the wrap
    rd0 = rd_n;
    bus_start();
    byte_out(8'hAA, a);
    byte_out(8'h7F, a);
    byte_out(8'hFE, a);
    bus_start();
    byte_out(8'hAB, a); chk("R2 read address ack", a, 1);
    byte_in(1'b1, d); chk("R6 byte at 7FFE", d, mem_f(15'h7FFE));
    byte_in(1'b1, d); chk("R6 byte at 7FFF", d, mem_f(15'h7FFF));
    byte_in(1'b0, d); chk("R6 wrap to 0000", d, mem_f(15'h0000));
    wq(2*Q);
    chk("R7 sda released after NACK", sda_pull, 0);
    bus_stop();
    wq(10);
    chk("R7 no read after NACK", rd_n - rd0, 3);
    chk("R4 header without data writes nothing", wr_n, wr0 + 2);

    // current-address read continues from pointer
    bus_start();
    byte_out(8'hAB, a);
    byte_in(1'b0, d); chk("R6 sequential pointer", d, mem_f(15'h0001));
    bus_stop();

    // R8: START in the middle of a data byte
    wr0 = wr_n;
    bus_start();
    byte_out(8'hAA, a);
    byte_out(8'h00, a);
    byte_out(8'h10, a);
    send_bits(8'hC3, 4);
    bus_start();
    byte_out(8'hAA, a); chk("R8 address reception after abort", a, 1);
    bus_stop();
    wq(10);
    chk("R8 no write from partial byte", wr_n, wr0);
    bus_start();
    byte_out(8'hAB, a);
    byte_in(1'b0, d); chk("R8 pointer kept", d, mem_f(15'h0010));
    bus_stop();

    summary();
    $finish;
  end
endmodule